// File: doc/BRIEF.md
# PCI Function Event Queue

This block keeps a small ordered backlog of events that describe what has happened to PCI functions: errors raised while a function runs, and changes in its availability as it is plugged or unplugged. Producers hand in events through a direct push port or through two sequencing inputs that stand for a hot-plug and a hot-unplug. Each sequencing request expands into a fixed, ordered set of availability events. Every cycle in which at least one event enters the backlog is announced by a one-cycle notification pulse toward the channel subsystem. A level output stays high while anything is waiting.

A single consumer port takes the oldest event and returns it as a fixed-size, typed response record. Multi-byte fields are big-endian. The payload that is filled depends on the event type. A pop made while the backlog is empty returns a "nothing pending" status. Direct pushes with an unknown type code are refused and flagged. Events that find no room are dropped and raise a sticky overflow flag.

Top module: `fn_evt_queue`

## Requirements
- R1: A direct push uses type code 1 for an error event and 2 for an availability event. Any other code is not queued, and `kind_bad` is high for exactly the one cycle after that push.
- R2: The record is 208 bits, with byte 0 at bits 207:200 and every field most significant byte first. It holds a length of 16'd26, a notification type of 8'd2, the type code (8 bits), the function ID and the function handle. An error record then holds the qualifier (32), the address (64) and the event code (16). An availability record then holds the event code followed by 96 zero bits.
- R3: A pop on a non-empty queue gives `rsp_valid` one cycle later, with `rsp_status`=0 and the record of the oldest entry. A pop on an empty queue gives `rsp_status`=1 with an all-zero record and leaves the queue unchanged.
- R4: `notify` is a one-cycle pulse. It is high in the cycle after any cycle in which at least one event was accepted, and low otherwise.
- R5: `have_event` is high exactly when the queue holds at least one entry. It reflects enqueues and dequeues from the cycle after they happen.
- R6: A hot-plug request queues two availability events carrying `fn_fid` and `fn_fh`: code 16'h0302 (reserved to standby) first, then 16'h0301 (standby to configured).
- R7: A hot-unplug request queues code 16'h0304 (configured to standby) only when `fn_configured` is high. It then always queues code 16'h0308 (standby to reserved).
- R8: If hot-plug and hot-unplug are requested in the same cycle, the hot-plug is served and the unplug is ignored. A direct push in that same cycle is queued after the sequence events.
- R9: The queue holds DEPTH entries (default 8). Events that do not fit are dropped, the latest of the cycle first. The `overflow` output becomes 1 in the cycle after a drop and stays 1 until reset.
- R10: A push and a pop in the same cycle are both honoured and the pop returns the older entry. A pop on a full queue frees one slot for that same cycle's push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Direct event push |
| push_kind | input | 8 | Type code of the pushed event |
| push_fid | input | 32 | Function ID |
| push_fh | input | 32 | Function handle |
| push_qual | input | 32 | Event qualifier (error events) |
| push_addr | input | 64 | Faulting address (error events) |
| push_code | input | 16 | Event code |
| plug_req | input | 1 | Hot-plug request |
| unplug_req | input | 1 | Hot-unplug request |
| fn_fid | input | 32 | Function ID for plug and unplug events |
| fn_fh | input | 32 | Function handle for plug and unplug events |
| fn_configured | input | 1 | Function is currently configured |
| pop_req | input | 1 | Consumer pop |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 1 | 0 = record returned, 1 = nothing pending |
| rsp_record | output | 208 | Formatted record |
| have_event | output | 1 | Queue non-empty |
| notify | output | 1 | Event-queued pulse |
| kind_bad | output | 1 | Illegal type code seen |
| overflow | output | 1 | Sticky drop flag |

## Verification
The bench fills the queue to the brim and pushes once more. A design that wrapped its write pointer would overwrite the oldest record, and a design that did not latch the drop would let `overflow` fall again. A push combined with a pop at full checks that the slot is reused in the same cycle; a design that checks space before the pop would drop the push. Hot-plug combined with a direct push, and unplug with and without `fn_configured`, catch wrong event order, a missing conditional event, or a lost push. An empty pop and an illegal type code must leave `have_event` and `notify` quiet, and an availability record must carry zeros where error fields would sit.

// File: rtl/fn_evt_pkg.sv
`timescale 1ns/1ps
package fn_evt_pkg;

    localparam int REC_BYTES = 26;
    localparam int REC_W     = REC_BYTES * 8;
    localparam int NSLOT     = 3;   // max events entering per cycle

    localparam logic [7:0]  KIND_ERR   = 8'd1;
    localparam logic [7:0]  KIND_AVAIL = 8'd2;
    localparam logic [7:0]  NOTE_TYPE  = 8'd2;

    localparam logic [15:0] EC_RSV_TO_STBY = 16'h0302;
    localparam logic [15:0] EC_STBY_TO_CFG = 16'h0301;
    localparam logic [15:0] EC_CFG_TO_STBY = 16'h0304;
    localparam logic [15:0] EC_STBY_TO_RSV = 16'h0308;

    typedef struct packed {
        logic        is_err;
        logic [31:0] fid;
        logic [31:0] fh;
        logic [31:0] qual;
        logic [63:0] addr;
        logic [15:0] code;
    } evt_t;

    function automatic evt_t mk_avail(logic [31:0] fid, logic [31:0] fh,
                                      logic [15:0] code);
        evt_t e;
        e.is_err = 1'b0;
        e.fid    = fid;
        e.fh     = fh;
        e.qual   = '0;
        e.addr   = '0;
        e.code   = code;
        return e;
    endfunction

    function automatic logic [REC_W-1:0] fmt_record(evt_t e);
        if (e.is_err)
            return {16'(REC_BYTES), NOTE_TYPE, KIND_ERR, e.fid, e.fh,
                    e.qual, e.addr, e.code};
        else
            return {16'(REC_BYTES), NOTE_TYPE, KIND_AVAIL, e.fid, e.fh,
                    e.code, 96'd0};
    endfunction

endpackage

// File: rtl/fn_evt_seq.sv
`timescale 1ns/1ps
module fn_evt_seq
    import fn_evt_pkg::*;
(
    input  logic        push_valid,
    input  logic [7:0]  push_kind,
    input  logic [31:0] push_fid,
    input  logic [31:0] push_fh,
    input  logic [31:0] push_qual,
    input  logic [63:0] push_addr,
    input  logic [15:0] push_code,
    input  logic        plug_req,
    input  logic        unplug_req,
    input  logic [31:0] fn_fid,
    input  logic [31:0] fn_fh,
    input  logic        fn_configured,
    output logic [NSLOT-1:0] slot_vld,
    output evt_t [NSLOT-1:0] slot_ent,
    output logic        kind_bad
);

    logic       kind_ok;
    logic [1:0] n_seq;
    logic [1:0] n_all;

    always_comb begin
        slot_ent = '0;
        n_seq    = 2'd0;
        if (plug_req) begin
            slot_ent[0] = mk_avail(fn_fid, fn_fh, EC_RSV_TO_STBY);
            slot_ent[1] = mk_avail(fn_fid, fn_fh, EC_STBY_TO_CFG);
            n_seq       = 2'd2;
        end else if (unplug_req) begin
            if (fn_configured) begin
                slot_ent[0] = mk_avail(fn_fid, fn_fh, EC_CFG_TO_STBY);
                slot_ent[1] = mk_avail(fn_fid, fn_fh, EC_STBY_TO_RSV);
                n_seq       = 2'd2;
            end else begin
                slot_ent[0] = mk_avail(fn_fid, fn_fh, EC_STBY_TO_RSV);
                n_seq       = 2'd1;
            end
        end

        kind_ok  = (push_kind == KIND_ERR) || (push_kind == KIND_AVAIL);
        kind_bad = push_valid && !kind_ok;
        n_all    = n_seq;
        if (push_valid && kind_ok) begin
            slot_ent[n_seq].is_err = (push_kind == KIND_ERR);
            slot_ent[n_seq].fid    = push_fid;
            slot_ent[n_seq].fh     = push_fh;
            slot_ent[n_seq].qual   = push_qual;
            slot_ent[n_seq].addr   = push_addr;
            slot_ent[n_seq].code   = push_code;
            n_all = n_seq + 2'd1;
        end

        for (int i = 0; i < NSLOT; i++)
            slot_vld[i] = (i < int'(n_all));
    end

endmodule

// File: rtl/fn_evt_fifo.sv
`timescale 1ns/1ps
module fn_evt_fifo
    import fn_evt_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NW    = NSLOT
)(
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] wr_vld,
    input  evt_t [NW-1:0] wr_ent,
    input  logic          rd_en,
    output evt_t          head,
    output logic          empty,
    output logic          acc_any,
    output logic          dropped
);

    localparam int PTRW = $clog2(DEPTH);
    localparam int CNTW = PTRW + 1;

    evt_t            mem [DEPTH];
    logic [PTRW-1:0] wr_ptr, rd_ptr;
    logic [CNTW-1:0] cnt;
    logic            rd_ok;
    logic [NW-1:0]   acc;
    int              free;
    int              n_acc;

    always_comb begin
        rd_ok   = rd_en && (cnt != '0);
        free    = DEPTH - int'(cnt) + (rd_ok ? 1 : 0);
        acc     = '0;
        n_acc   = 0;
        dropped = 1'b0;
        for (int i = 0; i < NW; i++) begin
            if (wr_vld[i]) begin
                if (i < free) begin
                    acc[i] = 1'b1;
                    n_acc  = n_acc + 1;
                end else begin
                    dropped = 1'b1;
                end
            end
        end
        acc_any = (acc != '0);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NW; i++)
            if (acc[i])
                mem[wr_ptr + PTRW'(i)] <= wr_ent[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTRW'(n_acc);
            rd_ptr <= rd_ptr + PTRW'(rd_ok);
            cnt    <= cnt + CNTW'(n_acc) - CNTW'(rd_ok);
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (cnt == '0);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= DEPTH);

    p_empty_pop_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty && wr_vld == '0) |=> empty);

    p_drop_only_full_r9: assert property (@(posedge clk) disable iff (rst)
        dropped |=> (int'(cnt) == DEPTH));

endmodule

// File: rtl/fn_evt_rsp.sv
`timescale 1ns/1ps
module fn_evt_rsp
    import fn_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pop_req,
    input  logic             empty,
    input  evt_t             head,
    output logic             rsp_valid,
    output logic             rsp_status,
    output logic [REC_W-1:0] rsp_record
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_status <= 1'b0;
            rsp_record <= '0;
        end else begin
            rsp_valid  <= pop_req;
            rsp_status <= pop_req && empty;
            rsp_record <= (pop_req && !empty) ? fmt_record(head) : '0;
        end
    end

    p_ok_needs_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_status) |-> $past(!empty));

    p_rsp_len_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_status) |-> (rsp_record[REC_W-1 -: 16] == 16'(REC_BYTES)));

endmodule

// File: rtl/fn_evt_queue.sv
`timescale 1ns/1ps
module fn_evt_queue
    import fn_evt_pkg::*;
#(
    parameter int DEPTH = 8
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  logic [7:0]       push_kind,
    input  logic [31:0]      push_fid,
    input  logic [31:0]      push_fh,
    input  logic [31:0]      push_qual,
    input  logic [63:0]      push_addr,
    input  logic [15:0]      push_code,
    input  logic             plug_req,
    input  logic             unplug_req,
    input  logic [31:0]      fn_fid,
    input  logic [31:0]      fn_fh,
    input  logic             fn_configured,
    input  logic             pop_req,
    output logic             rsp_valid,
    output logic             rsp_status,
    output logic [REC_W-1:0] rsp_record,
    output logic             have_event,
    output logic             notify,
    output logic             kind_bad,
    output logic             overflow
);

    logic [NSLOT-1:0] slot_vld;
    evt_t [NSLOT-1:0] slot_ent;
    logic             bad_now;
    evt_t             head;
    logic             empty;
    logic             acc_any;
    logic             dropped;

    fn_evt_seq u_seq (
        .push_valid   (push_valid),
        .push_kind    (push_kind),
        .push_fid     (push_fid),
        .push_fh      (push_fh),
        .push_qual    (push_qual),
        .push_addr    (push_addr),
        .push_code    (push_code),
        .plug_req     (plug_req),
        .unplug_req   (unplug_req),
        .fn_fid       (fn_fid),
        .fn_fh        (fn_fh),
        .fn_configured(fn_configured),
        .slot_vld     (slot_vld),
        .slot_ent     (slot_ent),
        .kind_bad     (bad_now)
    );

    fn_evt_fifo #(.DEPTH(DEPTH), .NW(NSLOT)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .wr_vld (slot_vld),
        .wr_ent (slot_ent),
        .rd_en  (pop_req),
        .head   (head),
        .empty  (empty),
        .acc_any(acc_any),
        .dropped(dropped)
    );

    fn_evt_rsp u_rsp (
        .clk       (clk),
        .rst       (rst),
        .pop_req   (pop_req),
        .empty     (empty),
        .head      (head),
        .rsp_valid (rsp_valid),
        .rsp_status(rsp_status),
        .rsp_record(rsp_record)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            notify   <= 1'b0;
            kind_bad <= 1'b0;
            overflow <= 1'b0;
        end else begin
            notify   <= acc_any;
            kind_bad <= bad_now;
            overflow <= overflow || dropped;
        end
    end

    assign have_event = !empty;

    p_notify_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        notify |-> have_event);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    p_slots_packed_r8: assert property (@(posedge clk) disable iff (rst)
        ((slot_vld & (slot_vld + 1'b1)) == '0));

    p_bad_not_queued_r1: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_kind != KIND_ERR && push_kind != KIND_AVAIL &&
         !plug_req && !unplug_req) |=> !notify);

    p_empty_pop_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!have_event && !push_valid && !plug_req && !unplug_req) |=> !have_event);

endmodule

// File: tb/fn_evt_queue_bench.sv
`timescale 1ns/1ps
module fn_evt_queue_bench;

    localparam int DEPTH = 8;
    localparam int RW    = 208;

    logic          clk = 1'b0;
    logic          rst;
    logic          push_valid;
    logic [7:0]    push_kind;
    logic [31:0]   push_fid, push_fh, push_qual;
    logic [63:0]   push_addr;
    logic [15:0]   push_code;
    logic          plug_req, unplug_req;
    logic [31:0]   fn_fid, fn_fh;
    logic          fn_configured;
    logic          pop_req;
    logic          rsp_valid, rsp_status;
    logic [RW-1:0] rsp_record;
    logic          have_event, notify, kind_bad, overflow;

    fn_evt_queue #(.DEPTH(DEPTH)) u_fn_evt_queue (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_kind(push_kind),
        .push_fid(push_fid), .push_fh(push_fh), .push_qual(push_qual),
        .push_addr(push_addr), .push_code(push_code),
        .plug_req(plug_req), .unplug_req(unplug_req),
        .fn_fid(fn_fid), .fn_fh(fn_fh), .fn_configured(fn_configured),
        .pop_req(pop_req),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_record(rsp_record),
        .have_event(have_event), .notify(notify), .kind_bad(kind_bad),
        .overflow(overflow)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [RW-1:0] model_q [$];
    logic [RW:0]   exp_rsp [$];
    bit            m_ovf = 0;

    task automatic chk(bit ok, string req, logic [RW:0] act, logic [RW:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] rec_err(logic [31:0] fid, logic [31:0] fh,
            logic [31:0] q, logic [63:0] a, logic [15:0] c);
        return {16'd26, 8'd2, 8'd1, fid, fh, q, a, c};
    endfunction

    function automatic logic [RW-1:0] rec_av(logic [31:0] fid, logic [31:0] fh,
            logic [15:0] c);
        return {16'd26, 8'd2, 8'd2, fid, fh, c, 96'd0};
    endfunction

    task automatic idle_inputs();
        push_valid = 0; push_kind = 0; push_fid = 0; push_fh = 0;
        push_qual = 0; push_addr = 0; push_code = 0;
        plug_req = 0; unplug_req = 0; fn_fid = 0; fn_fh = 0;
        fn_configured = 0; pop_req = 0;
    endtask

    // one cycle of stimulus; model updated, then mid-cycle port checks
    task automatic step(bit pv, logic [7:0] kind, logic [31:0] fid, logic [31:0] fh,
            logic [31:0] q, logic [63:0] a, logic [15:0] c,
            bit plug, bit unplug, logic [31:0] ffid, logic [31:0] ffh, bit cfg, bit pop);
        logic [RW-1:0] adds [$];
        logic [RW:0]   er;
        bit            has_rsp = 0;
        bit            acc = 0;
        bit            bad;
        @(negedge clk);
        push_valid = pv; push_kind = kind; push_fid = fid; push_fh = fh;
        push_qual = q; push_addr = a; push_code = c;
        plug_req = plug; unplug_req = unplug; fn_fid = ffid; fn_fh = ffh;
        fn_configured = cfg; pop_req = pop;
        if (pop) begin
            has_rsp = 1;
            if (model_q.size() == 0) er = {1'b1, {RW{1'b0}}};
            else er = {1'b0, model_q.pop_front()};
        end
        if (plug) begin
            adds.push_back(rec_av(ffid, ffh, 16'h0302));
            adds.push_back(rec_av(ffid, ffh, 16'h0301));
        end else if (unplug) begin
            if (cfg) adds.push_back(rec_av(ffid, ffh, 16'h0304));
            adds.push_back(rec_av(ffid, ffh, 16'h0308));
        end
        bad = pv && kind != 8'd1 && kind != 8'd2;
        if (pv && kind == 8'd1) adds.push_back(rec_err(fid, fh, q, a, c));
        if (pv && kind == 8'd2) adds.push_back(rec_av(fid, fh, c));
        foreach (adds[i]) begin
            if (model_q.size() < DEPTH) begin
                model_q.push_back(adds[i]);
                acc = 1;
            end else m_ovf = 1;
        end
        @(posedge clk);
        #1;
        if (has_rsp) exp_rsp.push_back(er);
        idle_inputs();
        #5;
        chk(notify == acc, "R4 notify", notify, acc);
        chk(kind_bad == bad, "R1 kind_bad", kind_bad, bad);
        chk(have_event == (model_q.size() != 0), "R5 have_event",
            have_event, model_q.size() != 0);
        chk(overflow == m_ovf, "R9 overflow", overflow, m_ovf);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic pop();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    endtask

    // monitor: compares responses against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (exp_rsp.size() != 0) begin
                logic [RW:0] e;
                e = exp_rsp.pop_front();
                chk(rsp_valid == 1'b1, "R3 rsp_valid", rsp_valid, 1);
                chk(rsp_status == e[RW], "R3 status", rsp_status, e[RW]);
                chk(rsp_record == e[RW-1:0], "R2 R10 record", rsp_record, e[RW-1:0]);
            end else begin
                chk(rsp_valid == 1'b0, "R3 spurious rsp", rsp_valid, 0);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #5;
        // reset state
        chk(have_event == 0, "R5 reset have_event", have_event, 0);
        chk(notify == 0, "R4 reset notify", notify, 0);
        chk(overflow == 0, "R9 reset overflow", overflow, 0);
        chk(rsp_valid == 0, "R3 reset rsp_valid", rsp_valid, 0);

        // R3: empty pop
        pop();
        idle();

        // R1 R2: error then availability push, popped in order
        step(1, 8'd1, 32'h11, 32'h8011, 32'hA5A5_0001, 64'h0123_4567_89AB_CDEF,
             16'h003A, 0, 0, 0, 0, 0, 0);
        step(1, 8'd2, 32'h22, 32'h8022, 32'hFFFF_FFFF, 64'hFFFF, 16'h0301,
             0, 0, 0, 0, 0, 0);
        pop();
        pop();
        idle();

        // R1: illegal type codes not queued
        step(1, 8'd3, 32'h33, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 8'd0, 32'h34, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        pop();
        idle();

        // R6 plug, R7 unplug configured / not configured
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 32'h5, 32'h8005, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h6, 32'h8006, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h7, 32'h8007, 0, 0);
        repeat (6) pop();
        idle();

        // R8: plug and unplug together plus push
        step(1, 8'd1, 32'h9, 32'h8009, 32'h1, 64'h2000, 16'h0010,
             1, 1, 32'hA, 32'h800A, 1, 0);
        repeat (3) pop();
        idle();

        // R10: push with pop, pop returns the older entry
        step(1, 8'd2, 32'h40, 32'h8040, 0, 0, 16'h0302, 0, 0, 0, 0, 0, 0);
        step(1, 8'd2, 32'h41, 32'h8041, 0, 0, 16'h0302, 0, 0, 0, 0, 0, 1);
        pop();
        idle();

        // R9: fill, overflow, R10 push+pop at full
        for (int i = 0; i < DEPTH + 1; i++)
            step(1, 8'd1, 32'h100 + i, 32'h9000 + i, i, 64'(i) << 12, 16'h0020,
                 0, 0, 0, 0, 0, 0);
        step(1, 8'd1, 32'h1FF, 32'h91FF, 32'h7, 64'h7000, 16'h0021,
             0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 32'hB, 32'h800B, 0, 0);
        for (int i = 0; i < DEPTH + 1; i++) pop();
        idle();

        // R9: reset clears the sticky flag
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1 rst = 0;
        model_q.delete();
        m_ovf = 0;
        #5;
        chk(overflow == 0, "R9 overflow after reset", overflow, 0);
        chk(have_event == 0, "R5 empty after reset", have_event, 0);
        idle();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule